// File: doc/BRIEF.md
# Serial Port Register Bank with Hold-off Interrupts

This block is the host-visible face of a byte-wide serial port: eight byte registers behind a 3-bit offset. It sits between a host bus (offset, read strobe, write strobe, write byte, read byte) and a plain character channel. The channel offers a byte-waiting flag with the waiting byte, takes a pop strobe, and accepts transmit bytes with a push strobe. Baud timing, shifting, queues and modem pins live elsewhere.

The bank keeps interrupt enable, line control and modem control bytes. It reports a prioritised interrupt identity and a fixed-ready line status. Receive and transmit each have a pending bit. Most interrupt requests wait out a hold-off of `HOLDOFF` clock cycles before they raise their pending bit. A new request restarts the wait. Re-enabling transmit interrupts skips the wait when the previous transmit interrupt is old enough. The interrupt line is a register that follows the OR of the two pending bits.

Top module: `ser_regs`

## Requirements
- R1: After reset the enable, line control and modem control bytes are 0x00, both pending bits are clear, `irq_o` is low and the identity register (offset 2) reads 0x01.
- R2: With line-control bit 7 clear, a read at offset 0 pops the channel and returns the waiting byte, or 0x00 if none waits. The read clears receive-pending on its edge. If a byte is still waiting one cycle later and enable bit 0 is set, a receive hold-off starts on that next edge.
- R3: With line-control bit 7 clear, a write at offset 0 pushes the byte to the channel and clears transmit-pending on its edge. It starts a transmit hold-off when enable bit 1 is set.
- R4: With line-control bit 7 set, accesses at offsets 0 and 1 neither pop nor push and do not change the enable byte. Reads there return 0x00. Otherwise offset 1 reads and writes the enable byte.
- R5: A read at offset 2 returns 0x04 while receive is pending, else 0x02 while transmit is pending (and that read clears transmit-pending), else 0x01.
- R6: A read at offset 5 returns bits 6 and 5 set and bit 0 equal to the byte-waiting flag, with all other bits 0.
- R7: A write at offset 4 of 0x1A (loopback bit 4 with 0x0A) sets the modem control byte to 0x9A. Any other value leaves it unchanged. Offset 4 reads it back.
- R8: Offset 3 reads back the last line-control write. Offsets 6 and 7 read 0x00. Writes at offsets 2 and 7 change nothing.
- R9: A hold-off started on edge E sets its pending bit on edge E+`HOLDOFF` if its enable bit is set then. Starting it again before expiry restarts the count.
- R10: Writing the enable byte with bit 1 set raises transmit-pending on that edge when more than `HOLDOFF` cycles have passed since the last transmit interrupt. Otherwise it starts a transmit hold-off. Writing it with bit 1 clear cancels the transmit hold-off and clears transmit-pending.
- R11: Writing the enable byte with bit 0 set while a byte waits starts a receive hold-off. Any other enable write cancels the receive hold-off and clears receive-pending.
- R12: A rising byte-waiting flag sets receive-pending on the same edge when enable bit 0 is set.
- R13: `irq_o` changes on the same edge as the pending bits and equals their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid while rd_i is high |
| rx_avail_i | input | 1 | Channel has a received byte waiting |
| rx_data_i | input | 8 | Waiting received byte |
| rx_pop_o | output | 1 | Consume the waiting byte |
| tx_push_o | output | 1 | Push tx_data_o to the channel |
| tx_data_o | output | 8 | Byte to transmit |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong hold-off count or a timer that fails to restart shows as `irq_o` rising one or more cycles away from edge E+`HOLDOFF`. The bench samples the line on the cycles just before and just at that edge. A stuck pending bit shows at the next identity read as the wrong code, and as an `irq_o` that does not drop on the clearing edge. A bad line-control gate shows at once as a stray pop or push strobe on the channel.

// File: rtl/ser_regs_pkg.sv
package ser_regs_pkg;
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_IER  = 3'd1;
  localparam logic [2:0] OFF_IIR  = 3'd2;
  localparam logic [2:0] OFF_LCR  = 3'd3;
  localparam logic [2:0] OFF_MCR  = 3'd4;
  localparam logic [2:0] OFF_LSR  = 3'd5;
  localparam logic [2:0] OFF_MSR  = 3'd6;
  localparam logic [2:0] OFF_SCR  = 3'd7;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int LCR_GATE = 7;

  localparam logic [7:0] ID_RX   = 8'h04;
  localparam logic [7:0] ID_TX   = 8'h02;
  localparam logic [7:0] ID_NONE = 8'h01;

  localparam logic [7:0] MCR_PROBE  = 8'h1A;
  localparam logic [7:0] MCR_LOCKED = 8'h9A;

  typedef struct packed {
    logic data_rd;
    logic data_wr;
    logic ier_wr;
    logic iir_rd;
    logic lcr_wr;
    logic mcr_wr;
  } acc_t;
endpackage

// File: rtl/ser_regs_decode.sv
module ser_regs_decode
  import ser_regs_pkg::*;
(
  input  logic [2:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       gate_i,
  output acc_t       acc_o
);
  always_comb begin
    acc_o         = '0;
    acc_o.data_rd = rd_i && (addr_i == OFF_DATA) && !gate_i;
    acc_o.data_wr = wr_i && (addr_i == OFF_DATA) && !gate_i;
    acc_o.ier_wr  = wr_i && (addr_i == OFF_IER) && !gate_i;
    acc_o.iir_rd  = rd_i && (addr_i == OFF_IIR);
    acc_o.lcr_wr  = wr_i && (addr_i == OFF_LCR);
    acc_o.mcr_wr  = wr_i && (addr_i == OFF_MCR);
  end
endmodule

// File: rtl/ser_regs_timer.sv
module ser_regs_timer #(
  parameter int HOLDOFF = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sched_i,
  input  logic cancel_i,
  output logic fire_o
);
  localparam int CW = $clog2(HOLDOFF) + 1;
  localparam logic [CW-1:0] LOAD = CW'(HOLDOFF - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  assign fire_o = armed_q && (cnt_q == '0) && !sched_i && !cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (sched_i) begin
      cnt_q   <= LOAD;
      armed_q <= 1'b1;
    end else if (cancel_i || fire_o) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ser_regs_rdmux.sv
module ser_regs_rdmux
  import ser_regs_pkg::*;
(
  input  logic [2:0] addr_i,
  input  logic       rd_i,
  input  logic       gate_i,
  input  logic [7:0] ier_i,
  input  logic [7:0] lcr_i,
  input  logic [7:0] mcr_i,
  input  logic       rx_pend_i,
  input  logic       tx_pend_i,
  input  logic       rx_avail_i,
  input  logic [7:0] rx_data_i,
  output logic [7:0] rdata_o
);
  logic [7:0] val;

  always_comb begin
    val = '0;
    unique case (addr_i)
      OFF_DATA: val = (!gate_i && rx_avail_i) ? rx_data_i : 8'h00;
      OFF_IER:  val = gate_i ? 8'h00 : ier_i;
      OFF_IIR:  val = rx_pend_i ? ID_RX : (tx_pend_i ? ID_TX : ID_NONE);
      OFF_LCR:  val = lcr_i;
      OFF_MCR:  val = mcr_i;
      OFF_LSR:  val = {1'b0, 1'b1, 1'b1, 4'b0000, rx_avail_i};
      OFF_MSR:  val = 8'h00;
      OFF_SCR:  val = 8'h00;
      default:  val = 8'h00;
    endcase
  end

  assign rdata_o = rd_i ? val : 8'h00;
endmodule

// File: rtl/ser_regs.sv
module ser_regs
  import ser_regs_pkg::*;
#(
  parameter int HOLDOFF = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rx_avail_i,
  input  logic [7:0] rx_data_i,
  output logic       rx_pop_o,
  output logic       tx_push_o,
  output logic [7:0] tx_data_o,
  output logic       irq_o
);
  localparam int AW = $clog2(HOLDOFF + 2);
  localparam logic [AW-1:0] AGE_SAT = AW'(HOLDOFF + 1);

  logic [7:0]    ier_q, lcr_q, mcr_q;
  logic          rx_pend_q, tx_pend_q, irq_q;
  logic          rx_prev_q, pop_q;
  logic [AW-1:0] age_q;
  acc_t          acc;

  logic rx_sched, rx_cancel, rx_fire, rx_set;
  logic tx_sched, tx_cancel, tx_fire, tx_set, tx_imm, age_old;
  logic rx_pend_d, tx_pend_d;

  ser_regs_decode u_dec (
    .addr_i (addr_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .gate_i (lcr_q[LCR_GATE]),
    .acc_o  (acc)
  );

  ser_regs_rdmux u_rmux (
    .addr_i     (addr_i),
    .rd_i       (rd_i),
    .gate_i     (lcr_q[LCR_GATE]),
    .ier_i      (ier_q),
    .lcr_i      (lcr_q),
    .mcr_i      (mcr_q),
    .rx_pend_i  (rx_pend_q),
    .tx_pend_i  (tx_pend_q),
    .rx_avail_i (rx_avail_i),
    .rx_data_i  (rx_data_i),
    .rdata_o    (rdata_o)
  );

  assign rx_pop_o  = acc.data_rd;
  assign tx_push_o = acc.data_wr;
  assign tx_data_o = wdata_i;

  assign age_old   = (age_q > AW'(HOLDOFF));
  assign tx_imm    = acc.ier_wr && wdata_i[EN_TX] && age_old;
  assign tx_sched  = (acc.data_wr && ier_q[EN_TX]) ||
                     (acc.ier_wr && wdata_i[EN_TX] && !age_old);
  assign tx_cancel = acc.ier_wr && !wdata_i[EN_TX];

  // re-check one cycle after a pop: has more data arrived behind it
  assign rx_sched  = (pop_q && rx_avail_i && ier_q[EN_RX]) ||
                     (acc.ier_wr && wdata_i[EN_RX] && rx_avail_i);
  assign rx_cancel = acc.ier_wr && !(wdata_i[EN_RX] && rx_avail_i);

  ser_regs_timer #(.HOLDOFF(HOLDOFF)) u_rx_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sched_i  (rx_sched),
    .cancel_i (rx_cancel),
    .fire_o   (rx_fire)
  );

  ser_regs_timer #(.HOLDOFF(HOLDOFF)) u_tx_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sched_i  (tx_sched),
    .cancel_i (tx_cancel),
    .fire_o   (tx_fire)
  );

  assign rx_set = ier_q[EN_RX] && (rx_fire || (rx_avail_i && !rx_prev_q));
  assign tx_set = (tx_fire && ier_q[EN_TX]) || tx_imm;

  // set first, clears override
  always_comb begin
    rx_pend_d = rx_pend_q;
    if (rx_set) rx_pend_d = 1'b1;
    if (acc.data_rd || rx_cancel) rx_pend_d = 1'b0;

    tx_pend_d = tx_pend_q;
    if (tx_set) tx_pend_d = 1'b1;
    if (acc.data_wr || tx_cancel || (acc.iir_rd && !rx_pend_q && tx_pend_q))
      tx_pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q     <= '0;
      lcr_q     <= '0;
      mcr_q     <= '0;
      rx_pend_q <= 1'b0;
      tx_pend_q <= 1'b0;
      irq_q     <= 1'b0;
      rx_prev_q <= 1'b0;
      pop_q     <= 1'b0;
      age_q     <= AGE_SAT;
    end else begin
      if (acc.ier_wr) ier_q <= wdata_i;
      if (acc.lcr_wr) lcr_q <= wdata_i;
      if (acc.mcr_wr && (wdata_i == MCR_PROBE)) mcr_q <= MCR_LOCKED;
      rx_pend_q <= rx_pend_d;
      tx_pend_q <= tx_pend_d;
      irq_q     <= rx_pend_d | tx_pend_d;
      rx_prev_q <= rx_avail_i;
      pop_q     <= acc.data_rd;
      if (tx_set) age_q <= '0;
      else if (age_q != AGE_SAT) age_q <= age_q + 1'b1;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ser_regs_chk.sv
module ser_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] addr_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       rx_avail_i,
  input logic       rx_pop_o,
  input logic       tx_push_o,
  input logic [7:0] lcr_q,
  input logic [7:0] mcr_q,
  input logic       rx_pend_q,
  input logic       tx_pend_q
);
  // R4
  gate_blocks_channel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_q[7] |-> (!rx_pop_o && !tx_push_o));

  // R2
  pop_clears_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |=> !rx_pend_q);

  // R3
  push_clears_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |=> !tx_pend_q);

  // R5
  iir_tx_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd2 && rdata_o == 8'h02) |=> !tx_pend_q);

  // R6
  lsr_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd5) |-> (rdata_o == {1'b0, 2'b11, 4'b0, rx_avail_i}));

  // R7
  mcr_values_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcr_q == 8'h00) || (mcr_q == 8'h9A));

  // R10
  tx_disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd1 && !lcr_q[7] && !wdata_i[1]) |=> !tx_pend_q);
endmodule

bind ser_regs ser_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .rx_avail_i (rx_avail_i),
  .rx_pop_o   (rx_pop_o),
  .tx_push_o  (tx_push_o),
  .lcr_q      (lcr_q),
  .mcr_q      (mcr_q),
  .rx_pend_q  (rx_pend_q),
  .tx_pend_q  (tx_pend_q)
);

// File: tb/ser_regs_test.sv
`timescale 1ns/1ps
module ser_regs_test;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_avail;
  logic [7:0] rx_data;
  logic       rx_pop, tx_push, irq;
  logic [7:0] tx_data;

  int n_run = 0, n_fail = 0;
  logic [7:0] rxq [16];
  int rx_head = 0, rx_cnt = 0;
  int tx_cnt = 0;
  logic [7:0] tx_last = '0;
  logic [7:0] got;
  logic [7:0] m_lcr = '0, m_ier = '0, m_mcr = '0;
  int t0;

  always #5 clk = ~clk;

  assign rx_avail = (rx_cnt != 0);
  assign rx_data  = rxq[rx_head];

  ser_regs #(.HOLDOFF(H)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_avail_i(rx_avail),
    .rx_data_i(rx_data), .rx_pop_o(rx_pop), .tx_push_o(tx_push),
    .tx_data_o(tx_data), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (rx_pop && rx_cnt > 0) begin
      rx_head <= (rx_head + 1) % 16;
      rx_cnt  <= rx_cnt - 1;
    end
    if (tx_push) begin
      tx_last <= tx_data;
      tx_cnt  <= tx_cnt + 1;
    end
  end

  function automatic logic [7:0] mcr_after(logic [7:0] cur, logic [7:0] w);
    return (w == 8'h1A) ? 8'h9A : cur;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic push_rx(logic [7:0] b);
    rxq[(rx_head + rx_cnt) % 16] = b;
    rx_cnt = rx_cnt + 1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tick(2); rst_n = 1'b1; tick(1);

    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rreg(3'd1, got); chk("R1 ier", got, 8'h00);
    rreg(3'd2, got); chk("R1 iir", got, 8'h01);
    rreg(3'd3, got); chk("R1 lcr", got, 8'h00);
    rreg(3'd4, got); chk("R1 mcr", got, 8'h00);
    rreg(3'd5, got); chk("R6 lsr empty", got, 8'h60);
    rreg(3'd6, got); chk("R8 msr", got, 8'h00);
    rreg(3'd7, got); chk("R8 scr", got, 8'h00);

    // R10 immediate transmit interrupt, R5 ack, R13 irq follows
    wreg(3'd1, 8'h02); chk("R10 immediate irq", {7'b0, irq}, 8'h01);
    rreg(3'd2, got);   chk("R5 tx id", got, 8'h02);
    chk("R13 irq drops on ack", {7'b0, irq}, 8'h00);
    rreg(3'd2, got);   chk("R5 none id", got, 8'h01);

    // R3 / R9 transmit hold-off after data write
    t0 = tx_cnt;
    wreg(3'd0, 8'h55);
    chk("R3 pushed", 8'(tx_cnt - t0), 8'h01);
    chk("R3 data", tx_last, 8'h55);
    tick(H - 1); chk("R9 tx early", {7'b0, irq}, 8'h00);
    tick(1);     chk("R9 tx on time", {7'b0, irq}, 8'h01);

    // R10 delayed when last transmit interrupt is recent
    rreg(3'd2, got); chk("R5 tx ack", got, 8'h02);
    wreg(3'd1, 8'h02); chk("R10 no immediate", {7'b0, irq}, 8'h00);
    tick(H - 1); chk("R10 delayed early", {7'b0, irq}, 8'h00);
    tick(1);     chk("R10 delayed fire", {7'b0, irq}, 8'h01);
    rreg(3'd2, got);

    // R9 restart on reschedule
    wreg(3'd0, 8'hAA); tick(3);
    wreg(3'd0, 8'hBB);
    tick(H - 1); chk("R9 restart early", {7'b0, irq}, 8'h00);
    tick(1);     chk("R9 restart fire", {7'b0, irq}, 8'h01);
    rreg(3'd2, got);

    // R10 cancel
    wreg(3'd0, 8'h11);
    wreg(3'd1, 8'h00);
    tick(H + 2); chk("R10 cancel irq", {7'b0, irq}, 8'h00);
    rreg(3'd2, got); chk("R10 cancel id", got, 8'h01);

    // R12 arrival, R5 priority, R2 pop
    wreg(3'd1, 8'h01);
    push_rx(8'h3C);
    tick(1); chk("R12 arrival irq", {7'b0, irq}, 8'h01);
    tick(H + 1);
    wreg(3'd1, 8'h03);
    rreg(3'd2, got); chk("R5 rx priority", got, 8'h04);
    rreg(3'd5, got); chk("R6 lsr ready", got, 8'h61);
    rreg(3'd0, got); chk("R2 data", got, 8'h3C);
    chk("R13 tx keeps irq", {7'b0, irq}, 8'h01);
    rreg(3'd2, got); chk("R5 tx after rx", got, 8'h02);
    rreg(3'd2, got); chk("R5 drained", got, 8'h01);

    // R2 reschedule while data remains
    push_rx(8'hA1); push_rx(8'hA2);
    tick(1); chk("R12 second arrival", {7'b0, irq}, 8'h01);
    rreg(3'd0, got); chk("R2 first byte", got, 8'hA1);
    chk("R2 irq cleared", {7'b0, irq}, 8'h00);
    tick(H);     chk("R2 resched early", {7'b0, irq}, 8'h00);
    tick(1);     chk("R2 resched fire", {7'b0, irq}, 8'h01);
    rreg(3'd0, got); chk("R2 second byte", got, 8'hA2);
    tick(H + 2); chk("R2 no resched when empty", {7'b0, irq}, 8'h00);
    rreg(3'd0, got); chk("R2 empty read", got, 8'h00);

    // R11 receive enable write
    wreg(3'd1, 8'h00);
    push_rx(8'h77);
    tick(1); chk("R12 disabled no irq", {7'b0, irq}, 8'h00);
    wreg(3'd1, 8'h01); chk("R11 no immediate", {7'b0, irq}, 8'h00);
    tick(H - 1); chk("R11 early", {7'b0, irq}, 8'h00);
    tick(1);     chk("R11 fire", {7'b0, irq}, 8'h01);
    wreg(3'd1, 8'h00); chk("R11 disable clears", {7'b0, irq}, 8'h00);
    rreg(3'd0, got); chk("R2 pop 77", got, 8'h77);

    // R4 gate
    wreg(3'd3, 8'h80);
    t0 = tx_cnt;
    wreg(3'd0, 8'h99); chk("R4 no push", 8'(tx_cnt - t0), 8'h00);
    wreg(3'd1, 8'h03);
    push_rx(8'hC5);
    rreg(3'd0, got); chk("R4 gated data read", got, 8'h00);
    rreg(3'd3, got); chk("R8 lcr readback", got, 8'h80);
    wreg(3'd3, 8'h00);
    rreg(3'd1, got); chk("R4 ier untouched", got, 8'h00);
    rreg(3'd0, got); chk("R4 no pop under gate", got, 8'hC5);

    // R7 modem control probe
    wreg(3'd4, 8'hFF); rreg(3'd4, got); chk("R7 other ignored", got, 8'h00);
    wreg(3'd4, 8'h1A); rreg(3'd4, got); chk("R7 probe", got, 8'h9A);
    wreg(3'd4, 8'h00); rreg(3'd4, got); chk("R7 sticky", got, 8'h9A);

    // R8 / R4 / R7 random register traffic
    m_lcr = 8'h00; m_ier = 8'h00; m_mcr = 8'h9A;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] v;
      int op;
      v  = 8'($urandom);
      op = int'($urandom % 7);
      case (op)
        0: begin wreg(3'd3, v); m_lcr = v; end
        1: begin wreg(3'd1, v & 8'hFC); if (!m_lcr[7]) m_ier = v & 8'hFC; end
        2: begin wreg(3'd4, (v[0]) ? 8'h1A : v); m_mcr = mcr_after(m_mcr, v[0] ? 8'h1A : v); end
        3: begin wreg(3'd2, v); wreg(3'd7, v); end
        4: begin rreg(3'd3, got); chk("R8 rand lcr", got, m_lcr); end
        5: begin rreg(3'd1, got); chk("R4 rand ier", got, m_lcr[7] ? 8'h00 : m_ier); end
        default: begin
          rreg(3'd7, got); chk("R8 rand scr", got, 8'h00);
          rreg(3'd4, got); chk("R7 rand mcr", got, m_mcr);
        end
      endcase
    end
    finish_run();
  end
endmodule